// File: doc/BRIEF.md
# Associative Memory with Free-Slot Tracking

This block is a small content-addressable memory. Each of its entries holds a data word and an empty flag. Software or a control engine fills it in one of three ways: by an explicit address, by an address held in an internal pointer register, or by asking the block to place the word in its lowest-numbered empty slot. Entries can be read back by address, together with their empty flag.

A search operation presents a key. The key is compared in parallel against every entry whose empty flag is clear. The block returns a hit flag and the lowest-numbered matching entry, since entry 0 has the highest priority. The block also keeps a priority-encoded free pointer at all times. That pointer can be read as a fixed-format status word carrying a page number, and a full flag is raised when no slot is left.

All operations are single-cycle requests on one command port. Results come out of registers one cycle after the request.

Top module: `cam_nf`

## Requirements
- R1: After synchronous reset every entry is empty, the pointer register holds 0 and `full` is low.
- R2: A write (op 1) with `use_ptr`=0 stores `wdata` at `addr` and sets the entry's empty flag from `wempty`. A read (op 2) with `use_ptr`=0 returns that entry's data on `rdata` and its empty flag on `rempty`.
- R3: Op 6 loads `addr` into the pointer register. Writes and reads with `use_ptr`=1 take their address from that register instead of from `addr`.
- R4: A search (op 3) only reports entries whose empty flag is 0. An empty entry that holds the key is never a hit.
- R5: When several valid entries hold the key, `hit_addr` is the lowest-numbered one.
- R6: A free-word read (op 5) returns the page number in bits 19:16 and the lowest-numbered empty entry in the low address bits. Every other bit is 0.
- R7: Starting from an empty memory, successive free-slot writes (op 4) land in entries 0, 1, 2 and so on in order.
- R8: With no empty entry, `full` is high and a free-slot write changes no entry.
- R9: Writing an entry with `wempty`=1 makes it empty again. It then drops out of searches and becomes the free slot if it is the lowest-numbered empty one.
- R10: `rvalid` is high in exactly the cycle after a read or free-word read request. `sval` is high in exactly the cycle after a search request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| op | input | 3 | Operation: 1 write, 2 read, 3 search, 4 free-slot write, 5 free-word read, 6 load pointer |
| use_ptr | input | 1 | Take the address from the pointer register |
| addr | input | AW | Direct address |
| wdata | input | WIDTH | Write data or search key |
| wempty | input | 1 | Empty flag to store on write |
| rvalid | output | 1 | Read result valid |
| rdata | output | WIDTH | Read data or free word |
| rempty | output | 1 | Empty flag of the entry read |
| sval | output | 1 | Search result valid |
| hit | output | 1 | Search found a valid match |
| hit_addr | output | AW | Lowest matching entry |
| full | output | 1 | No empty entry remains |

## Verification
The properties assume that at most one operation is issued per cycle and that `op` carries only the listed codes while `req` is high. The bench drives every request for exactly one clock, from the falling edge, and always uses defined codes. The ordering properties assume that free-slot writes store `wempty`=0, which the fill sequences keep to. Deliberate empty-flag writes are only made by address.

// File: rtl/cam_nf_pkg.sv
package cam_nf_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_SEARCH  = 3'd3,
    OP_WR_FREE = 3'd4,
    OP_RD_FREE = 3'd5,
    OP_LD_PTR  = 3'd6
  } cam_op_e;

  localparam int unsigned FREE_WORD_W  = 32;
  localparam int unsigned PAGE_LSB     = 16;
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int unsigned N  = 64,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [AW-1:0] idx
);
  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = AW'(i);
      end
    end
  end
endmodule

// File: rtl/cam_store.sv
module cam_store #(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [WIDTH-1:0]   wword,
  input  logic               wflag,
  input  logic               re,
  input  logic [AW-1:0]      raddr,
  input  logic [WIDTH-1:0]   key,
  output logic [WIDTH-1:0]   rword,
  output logic               rflag,
  output logic [ENTRIES-1:0] empty_vec,
  output logic [ENTRIES-1:0] hit_vec
);
  logic [WIDTH-1:0]   mem [ENTRIES];
  logic [ENTRIES-1:0] empty_q;

  // data array: no reset so it maps to plain storage
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  always_ff @(posedge clk) begin
    if (re) rword <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= '1;
      rflag   <= 1'b1;
    end else begin
      if (we) empty_q[waddr] <= wflag;
      if (re) rflag <= empty_q[raddr];
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = !empty_q[g] && (mem[g] == key);
    end
  endgenerate

  assign empty_vec = empty_q;
endmodule

// File: rtl/cam_nf.sv
module cam_nf
  import cam_nf_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned PAGE_W  = 4,
  parameter logic [PAGE_W-1:0] PAGE_ID = 4'hA,
  localparam int unsigned AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [2:0]       op,
  input  logic             use_ptr,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             wempty,
  output logic             rvalid,
  output logic [WIDTH-1:0] rdata,
  output logic             rempty,
  output logic             sval,
  output logic             hit,
  output logic [AW-1:0]    hit_addr,
  output logic             full
);
  cam_op_e op_e;
  assign op_e = cam_op_e'(op);

  logic [AW-1:0]      ptr_q;
  logic [AW-1:0]      free_addr, hit_idx, rand_addr;
  logic               free_found, hit_found;
  logic [ENTRIES-1:0] empty_vec, hit_vec;
  logic               st_we, st_re;
  logic [AW-1:0]      st_waddr;
  logic [WIDTH-1:0]   st_rword;
  logic               st_rflag;
  logic [FREE_WORD_W-1:0] free_word, free_word_q;
  logic               sel_free_q;

  assign rand_addr = use_ptr ? ptr_q : addr;
  assign full      = !free_found;

  always_comb begin
    st_we    = 1'b0;
    st_waddr = rand_addr;
    if (req) begin
      if (op_e == OP_WRITE) st_we = 1'b1;
      else if (op_e == OP_WR_FREE) begin
        st_we    = free_found;
        st_waddr = free_addr;
      end
    end
  end
  assign st_re = req && (op_e == OP_READ);

  cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .we(st_we), .waddr(st_waddr), .wword(wdata), .wflag(wempty),
    .re(st_re), .raddr(rand_addr), .key(wdata),
    .rword(st_rword), .rflag(st_rflag),
    .empty_vec(empty_vec), .hit_vec(hit_vec)
  );

  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
    .vec(empty_vec), .found(free_found), .idx(free_addr)
  );

  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
    .vec(hit_vec), .found(hit_found), .idx(hit_idx)
  );

  always_comb begin
    free_word = '0;
    free_word[PAGE_LSB +: PAGE_W] = PAGE_ID;
    free_word[AW-1:0] = free_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q       <= '0;
      rvalid      <= 1'b0;
      sval        <= 1'b0;
      hit         <= 1'b0;
      hit_addr    <= '0;
      sel_free_q  <= 1'b0;
      free_word_q <= '0;
    end else begin
      rvalid <= req && (op_e == OP_READ || op_e == OP_RD_FREE);
      sval   <= req && (op_e == OP_SEARCH);
      if (req && op_e == OP_LD_PTR) ptr_q <= addr;
      if (req && op_e == OP_SEARCH) begin
        hit      <= hit_found;
        hit_addr <= hit_idx;
      end
      if (req && (op_e == OP_READ || op_e == OP_RD_FREE))
        sel_free_q <= (op_e == OP_RD_FREE);
      if (req && op_e == OP_RD_FREE) free_word_q <= free_word;
    end
  end

  assign rdata  = sel_free_q ? WIDTH'(free_word_q) : st_rword;
  assign rempty = sel_free_q ? 1'b0 : st_rflag;
endmodule

// File: rtl/cam_nf_chk.sv
module cam_nf_chk
  import cam_nf_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  parameter int unsigned AW      = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic [2:0]         op,
  input logic               wempty,
  input logic               rvalid,
  input logic               sval,
  input logic               hit,
  input logic [AW-1:0]      hit_addr,
  input logic               full,
  input logic [ENTRIES-1:0] empty_vec,
  input logic [AW-1:0]      free_addr,
  input logic [AW-1:0]      ptr_q
);
  logic               rst_d;
  logic [ENTRIES-1:0] empty_d;
  logic               rd_req, s_req;

  assign rd_req = req && (op == 3'(OP_READ) || op == 3'(OP_RD_FREE));
  assign s_req  = req && (op == 3'(OP_SEARCH));

  always_ff @(posedge clk) begin
    rst_d   <= rst;
    empty_d <= empty_vec;
    if (rst_d) begin
      a_r1_reset_state: assert (&empty_vec && ptr_q == '0 && !full)
        else $error("R1 reset state wrong");
    end
  end

  a_r10_read_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid);
  a_r10_read_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rvalid);
  a_r10_search_pulse: assert property (@(posedge clk) disable iff (rst)
    s_req |=> sval);
  a_r10_search_quiet: assert property (@(posedge clk) disable iff (rst)
    !s_req |=> !sval);
  a_r4_hit_was_valid: assert property (@(posedge clk) disable iff (rst || rst_d)
    (sval && hit) |-> !empty_d[hit_addr]);
  a_r8_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (req && op == 3'(OP_WR_FREE) && full) |=> $stable(empty_vec));
  a_r7_free_advances: assert property (@(posedge clk) disable iff (rst)
    (req && op == 3'(OP_WR_FREE) && !full && !wempty) |=>
      (full || free_addr != $past(free_addr)));
  a_r6_free_is_empty: assert property (@(posedge clk) disable iff (rst)
    !full |-> empty_vec[free_addr]);
endmodule

bind cam_nf cam_nf_chk #(.ENTRIES(ENTRIES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req(req), .op(op), .wempty(wempty),
  .rvalid(rvalid), .sval(sval), .hit(hit), .hit_addr(hit_addr),
  .full(full), .empty_vec(empty_vec), .free_addr(free_addr), .ptr_q(ptr_q)
);

// File: tb/tb_cam_nf.sv
module tb_cam_nf;
  localparam int CLK_P = 10;
  localparam int N     = 64;
  localparam int AW    = 6;
  localparam logic [3:0] PAGE = 4'hA;

  logic clk = 0, rst = 1, req = 0, use_ptr = 0, wempty = 0;
  logic [2:0] op = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic rvalid, rempty, sval, hit, full;
  logic [31:0] rdata;
  logic [AW-1:0] hit_addr;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cam_nf dut (.clk(clk), .rst(rst), .req(req), .op(op), .use_ptr(use_ptr),
    .addr(addr), .wdata(wdata), .wempty(wempty), .rvalid(rvalid),
    .rdata(rdata), .rempty(rempty), .sval(sval), .hit(hit),
    .hit_addr(hit_addr), .full(full));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] fword(input int a);
    return (32'(PAGE) << 16) | 32'(a);
  endfunction

  task automatic do_reset();
    req = 0; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic issue(input logic [2:0] o, input logic up, input int a, input logic [31:0] d, input logic e);
    req = 1; op = o; use_ptr = up; addr = AW'(a); wdata = d; wempty = e;
    @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(full == 0, "R1 full", 32'(full), 0);
    issue(2, 1, 0, 0, 0);
    chk(rempty == 1, "R1 entry0 empty via ptr", 32'(rempty), 1);
    issue(5, 0, 0, 0, 0);
    chk(rdata == fword(0), "R1 free word", rdata, fword(0));
  endtask

  task automatic t_direct();
    do_reset();
    issue(1, 0, 5, 32'hDEADBEEF, 0);
    issue(1, 0, 9, 32'h12345678, 1);
    issue(2, 0, 5, 0, 0);
    chk(rdata == 32'hDEADBEEF, "R2 data", rdata, 32'hDEADBEEF);
    chk(rempty == 0, "R2 valid flag", 32'(rempty), 0);
    issue(2, 0, 9, 0, 0);
    chk(rempty == 1, "R2 empty flag", 32'(rempty), 1);
    chk(rdata == 32'h12345678, "R2 data2", rdata, 32'h12345678);
  endtask

  task automatic t_ptr();
    do_reset();
    issue(6, 0, 17, 0, 0);
    issue(1, 1, 3, 32'hCAFE0011, 0);
    issue(2, 0, 17, 0, 0);
    chk(rdata == 32'hCAFE0011, "R3 indirect write", rdata, 32'hCAFE0011);
    issue(2, 0, 3, 0, 0);
    chk(rempty == 1, "R3 direct addr untouched", 32'(rempty), 1);
    issue(2, 1, 40, 0, 0);
    chk(rdata == 32'hCAFE0011, "R3 indirect read", rdata, 32'hCAFE0011);
  endtask

  task automatic t_search();
    do_reset();
    issue(1, 0, 1, 32'h0000BEEF, 1);
    issue(1, 0, 7, 32'h0000BEEF, 0);
    issue(1, 0, 3, 32'h0000BEEF, 0);
    issue(3, 0, 0, 32'h0000BEEF, 0);
    chk(hit == 1, "R4 hit", 32'(hit), 1);
    chk(hit_addr == 3, "R5 lowest valid match", 32'(hit_addr), 3);
    issue(3, 0, 0, 32'h0BAD0BAD, 0);
    chk(hit == 0, "R4 no match", 32'(hit), 0);
    issue(1, 0, 3, 32'h0000BEEF, 1);
    issue(1, 0, 7, 32'h0000BEEF, 1);
    issue(3, 0, 0, 32'h0000BEEF, 0);
    chk(hit == 0, "R4 empty entry ignored", 32'(hit), 0);
  endtask

  task automatic t_fill_free();
    do_reset();
    for (int i = 0; i < 3; i++) issue(4, 0, 0, 32'hA0 + 32'(i), 0);
    for (int i = 0; i < 3; i++) begin
      issue(2, 0, i, 0, 0);
      chk(rdata == 32'hA0 + 32'(i) && rempty == 0, "R7 fill order", rdata, 32'hA0 + 32'(i));
    end
    issue(5, 0, 0, 0, 0);
    chk(rdata == fword(3), "R6 free word format", rdata, fword(3));
    issue(1, 0, 1, 32'hA1, 1);
    issue(5, 0, 0, 0, 0);
    chk(rdata == fword(1), "R9 freed slot is next", rdata, fword(1));
    issue(3, 0, 0, 32'hA1, 0);
    chk(hit == 0, "R9 freed slot not searched", 32'(hit), 0);
    issue(4, 0, 0, 32'hB1, 0);
    issue(2, 0, 1, 0, 0);
    chk(rdata == 32'hB1, "R9 refill freed slot", rdata, 32'hB1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < N; i++) issue(4, 0, 0, 32'h1000 + 32'(i), 0);
    chk(full == 1, "R8 full", 32'(full), 1);
    issue(4, 0, 0, 32'hFFFF0000, 0);
    issue(3, 0, 0, 32'hFFFF0000, 0);
    chk(hit == 0, "R8 write ignored when full", 32'(hit), 0);
    issue(2, 0, N - 1, 0, 0);
    chk(rdata == 32'h1000 + 32'(N - 1), "R8 last entry kept", rdata, 32'h1000 + 32'(N - 1));
    issue(3, 0, 0, 32'h1000 + 40, 0);
    chk(hit == 1 && hit_addr == 40, "R5 search in full memory", 32'(hit_addr), 40);
  endtask

  task automatic t_latency();
    do_reset();
    chk(rvalid == 0 && sval == 0, "R10 idle", {30'b0, rvalid, sval}, 0);
    issue(2, 0, 0, 0, 0);
    chk(rvalid == 1 && sval == 0, "R10 read pulse", {30'b0, rvalid, sval}, 2);
    @(negedge clk);
    chk(rvalid == 0, "R10 read pulse ends", 32'(rvalid), 0);
    issue(3, 0, 0, 0, 0);
    chk(sval == 1 && rvalid == 0, "R10 search pulse", {30'b0, rvalid, sval}, 1);
    @(negedge clk);
    chk(sval == 0, "R10 search pulse ends", 32'(sval), 0);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_direct();
    t_ptr();
    t_search();
    t_fill_free();
    t_full();
    t_latency();
    finish_up();
  end
endmodule